// File: doc/BRIEF.md
# Core Control and Status Register Bank

This block is a small bank of registers that sits behind the control window of a bus slave and lets a host processor start, stop and watch an embedded processor core. Software holds the core in reset through a control register, programs the address the core should boot from, then releases the reset. The bank drives the core's reset line and boot address. It also samples the core's halted and fault outputs, which software can read back as a status word.

Requests arrive on a simple valid/ready port that carries an address, write data and a write enable. The bank accepts one request every cycle. It answers each request exactly one cycle later with read data and an error flag. The boot address is frozen while the core runs, so reprogramming it has no effect until the next time the core is released from reset.

Top module: `core_ctl_regs`

## Requirements
- R1: After system reset (synchronous, `rst_n` low), offset 0x0 reads 1, offset 0x4 reads 0, `core_rst` is 1 and `core_boot_pc` is 0.
- R2: A write to offset 0x0 stores bit 0 of the write data: 1 holds the core in reset and 0 releases it. `core_rst` takes the new value in the cycle after the write is accepted, and a read of 0x0 returns it in bit 0 with bits 31:1 zero.
- R3: Offset 0x4 is a 32-bit read/write start-address register.
- R4: While `core_rst` is 1, `core_boot_pc` follows the 0x4 register one cycle behind. While `core_rst` stays 0, `core_boot_pc` does not change, so a write to 0x4 while the core runs changes it only after the next hold and release.
- R5: A read of offset 0x8 returns bit 0 = `core_halted` and bit 1 = `core_fault`, as sampled in the cycle the request is accepted, with bits 31:2 zero.
- R6: While `core_rst` is 1, both status bits read 0 whatever the core outputs are.
- R7: A write to offset 0x8 changes no register and returns no error.
- R8: Any other offset in the window, including a non-word-aligned one, returns `rsp_err` = 1 with read data 0, and a write there changes no register.
- R9: `req_ready` is always 1, and `rsp_valid` is 1 exactly in the cycle after each accepted request.
- R10: While `rst_n` is low, `core_rst` is 1 from the first clock edge on, so the core sees its reset for at least one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bank and the core |
| rst_n | input | 1 | Synchronous system reset, active low |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Bank accepts a request this cycle |
| req_addr | input | ADDR_W | Byte offset within the control window |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the request accepted last cycle |
| rsp_rdata | output | 32 | Read data (0 for writes and errors) |
| rsp_err | output | 1 | Offset not decoded |
| core_rst | output | 1 | Reset to the core, active high |
| core_boot_pc | output | 32 | Start address presented to the core |
| core_halted | input | 1 | Core reports it has stopped |
| core_fault | input | 1 | Core reports a fault |

## Verification
The assertions assume the `core_halted` and `core_fault` inputs are never X, and that `req_addr` and `req_we` are known whenever `req_valid` is high. Their timing properties rely on `rst_n` being low at the first clock edge. The bench drives every input on the falling edge and holds `rst_n` low for several edges before the first request. It keeps the core status inputs at defined levels throughout, and it issues only one request at a time.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned OFF_CTL  = 'h0;
    localparam int unsigned OFF_PC   = 'h4;
    localparam int unsigned OFF_STAT = 'h8;

    typedef enum logic [1:0] {
        SEL_CTL  = 2'd0,
        SEL_PC   = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // bit order matters: bit 1 fault, bit 0 halted
    typedef struct packed {
        logic fault;
        logic halted;
    } core_stat_t;

    typedef struct packed {
        logic              valid;
        logic              we;
        reg_sel_e          sel;
        logic [DATA_W-1:0] wdata;
    } reg_req_t;

    typedef struct packed {
        logic              valid;
        logic              err;
        logic [DATA_W-1:0] rdata;
    } reg_rsp_t;

    function automatic core_stat_t mask_stat(input logic held, input core_stat_t raw);
        core_stat_t m;
        m.halted = raw.halted & ~held;
        m.fault  = raw.fault  & ~held;
        return m;
    endfunction

endpackage

// File: rtl/ccr_decode.sv
module ccr_decode
    import ccr_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              valid,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output reg_req_t          req
);
    localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFF_CTL);
    localparam logic [ADDR_W-1:0] A_PC   = ADDR_W'(OFF_PC);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);

    always_comb begin
        req.valid = valid;
        req.we    = we;
        req.wdata = wdata;
        if (addr == A_CTL)       req.sel = SEL_CTL;
        else if (addr == A_PC)   req.sel = SEL_PC;
        else if (addr == A_STAT) req.sel = SEL_STAT;
        else                     req.sel = SEL_NONE;
    end
endmodule

// File: rtl/ccr_regfile.sv
module ccr_regfile
    import ccr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  reg_req_t          req,
    output logic              hold_q,
    output logic [DATA_W-1:0] pc_q,
    output logic [DATA_W-1:0] boot_q
);
    logic wr;
    assign wr = req.valid & req.we;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b1;
            pc_q   <= '0;
            boot_q <= '0;
        end else begin
            if (wr && req.sel == SEL_CTL) hold_q <= req.wdata[0];
            if (wr && req.sel == SEL_PC)  pc_q   <= req.wdata;
            // boot address tracks the register only while the core is held
            if (hold_q) boot_q <= pc_q;
        end
    end
endmodule

// File: rtl/ccr_readmux.sv
module ccr_readmux
    import ccr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  reg_req_t          req,
    input  logic              hold_q,
    input  logic [DATA_W-1:0] pc_q,
    input  core_stat_t        stat,
    output reg_rsp_t          rsp
);
    logic [DATA_W-1:0] rd;
    logic              err;

    always_comb begin
        rd  = '0;
        err = 1'b0;
        case (req.sel)
            SEL_CTL:  rd = {{(DATA_W-1){1'b0}}, hold_q};
            SEL_PC:   rd = pc_q;
            SEL_STAT: rd = {{(DATA_W-2){1'b0}}, stat};
            default:  err = 1'b1;
        endcase
        if (req.we) rd = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp <= '0;
        end else begin
            rsp.valid <= req.valid;
            rsp.err   <= req.valid & err;
            rsp.rdata <= req.valid ? rd : '0;
        end
    end
endmodule

// File: rtl/core_ctl_regs.sv
module core_ctl_regs
    import ccr_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err,
    output logic              core_rst,
    output logic [31:0]       core_boot_pc,
    input  logic              core_halted,
    input  logic              core_fault
);
    reg_req_t          req;
    reg_rsp_t          rsp;
    logic              hold_q;
    logic [DATA_W-1:0] pc_q;
    logic [DATA_W-1:0] boot_q;
    core_stat_t        raw_stat;
    core_stat_t        stat;

    assign req_ready = 1'b1;
    assign raw_stat  = '{fault: core_fault, halted: core_halted};
    assign stat      = mask_stat(hold_q, raw_stat);

    ccr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .valid (req_valid & req_ready),
        .we    (req_we),
        .addr  (req_addr),
        .wdata (req_wdata),
        .req   (req)
    );

    ccr_regfile u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req),
        .hold_q (hold_q),
        .pc_q   (pc_q),
        .boot_q (boot_q)
    );

    ccr_readmux u_rmux (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req),
        .hold_q (hold_q),
        .pc_q   (pc_q),
        .stat   (stat),
        .rsp    (rsp)
    );

    assign rsp_valid    = rsp.valid;
    assign rsp_rdata    = rsp.rdata;
    assign rsp_err      = rsp.err;
    assign core_rst     = hold_q;
    assign core_boot_pc = boot_q;
endmodule

// File: rtl/ccr_checker.sv
module ccr_checker #(
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_we,
    input logic              rsp_valid,
    input logic [31:0]       rsp_rdata,
    input logic              rsp_err,
    input logic              core_rst,
    input logic [31:0]       core_boot_pc
);
    logic acc, is_stat, is_known;
    assign acc      = req_valid && req_ready;
    assign is_stat  = (req_addr == ADDR_W'(8));
    assign is_known = (req_addr == ADDR_W'(0)) || (req_addr == ADDR_W'(4)) || is_stat;

    assert_rsp_after_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid);
    assert_no_spurious_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !rsp_valid);
    assert_sysrst_holds_core_R10: assert property (@(posedge clk)
        !rst_n |=> core_rst);
    assert_boot_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !core_rst |=> (core_rst || $stable(core_boot_pc)));
    assert_stat_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_we && is_stat && core_rst) |=> (rsp_rdata == 32'd0));
    assert_stat_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_we && is_stat) |=> (rsp_rdata[31:2] == 30'd0));
    assert_undef_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !is_known) |=> (rsp_err && rsp_rdata == 32'd0));
    assert_known_no_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && is_known) |=> !rsp_err);
endmodule

bind core_ctl_regs ccr_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_addr     (req_addr),
    .req_we       (req_we),
    .rsp_valid    (rsp_valid),
    .rsp_rdata    (rsp_rdata),
    .rsp_err      (rsp_err),
    .core_rst     (core_rst),
    .core_boot_pc (core_boot_pc)
);

// File: tb/tb_core_ctl_regs.sv
module tb_core_ctl_regs;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_we = 1'b0;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid;
    logic [31:0]       rsp_rdata;
    logic              rsp_err;
    logic              core_rst;
    logic [31:0]       core_boot_pc;
    logic              core_halted = 1'b0;
    logic              core_fault = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    core_ctl_regs #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .core_rst(core_rst), .core_boot_pc(core_boot_pc),
        .core_halted(core_halted), .core_fault(core_fault)
    );

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic eq(input string rq, input logic [31:0] act, input logic [31:0] exp);
        check(act === exp, rq, act, exp);
    endtask

    // one request; response sampled at the next falling edge
    task automatic xfer(input logic [7:0] a, input logic w, input logic [31:0] d,
                        output logic [31:0] rd, output logic er);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_we = w; req_wdata = d;
        check(req_ready === 1'b1, "R9 ready", {31'd0, req_ready}, 32'd1);
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0;
        check(rsp_valid === 1'b1, "R9 rsp_valid", {31'd0, rsp_valid}, 32'd1);
        rd = rsp_rdata; er = rsp_err;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input logic exp_err, input string rq);
        logic [31:0] rd; logic er;
        xfer(a, 1'b0, 32'd0, rd, er);
        eq(rq, rd, exp);
        eq({rq, " err"}, {31'd0, er}, {31'd0, exp_err});
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic exp_err, input string rq);
        logic [31:0] rd; logic er;
        xfer(a, 1'b1, d, rd, er);
        eq({rq, " err"}, {31'd0, er}, {31'd0, exp_err});
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        @(negedge clk);
        eq("R10 core_rst in sysreset", {31'd0, core_rst}, 32'd1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        eq("R9 no rsp when idle", {31'd0, rsp_valid}, 32'd0);
        eq("R1 core_rst", {31'd0, core_rst}, 32'd1);
        eq("R1 boot_pc", core_boot_pc, 32'd0);
        rd_chk(8'h00, 32'd1, 1'b0, "R1 ctl reset");
        rd_chk(8'h04, 32'd0, 1'b0, "R1 pc reset");
    endtask

    task automatic t_pc_and_release;
        wr(8'h04, 32'h0000_1000, 1'b0, "R3 pc write");
        rd_chk(8'h04, 32'h0000_1000, 1'b0, "R3 pc read");
        wr(8'h04, 32'hDEAD_BEEF, 1'b0, "R3 pc write2");
        rd_chk(8'h04, 32'hDEAD_BEEF, 1'b0, "R3 pc read all bits");
        wr(8'h04, 32'h0000_0100, 1'b0, "R3 pc write3");
        wr(8'h00, 32'hFFFF_FFFE, 1'b0, "R2 release (bit0=0)");
        eq("R2 core released", {31'd0, core_rst}, 32'd0);
        eq("R4 boot latched", core_boot_pc, 32'h0000_0100);
        rd_chk(8'h00, 32'd0, 1'b0, "R2 ctl readback 0");
    endtask

    task automatic t_pc_while_running;
        wr(8'h04, 32'h0000_0200, 1'b0, "R4 pc write running");
        repeat (3) @(negedge clk);
        eq("R4 boot frozen", core_boot_pc, 32'h0000_0100);
        rd_chk(8'h04, 32'h0000_0200, 1'b0, "R4 pc register updated");
        wr(8'h00, 32'h0000_0001, 1'b0, "R2 hold");
        eq("R2 core held", {31'd0, core_rst}, 32'd1);
        @(negedge clk);
        eq("R4 boot follows while held", core_boot_pc, 32'h0000_0200);
        rd_chk(8'h00, 32'd1, 1'b0, "R2 ctl readback 1");
        wr(8'h00, 32'h0000_0000, 1'b0, "R2 release again");
        eq("R4 boot after re-release", core_boot_pc, 32'h0000_0200);
    endtask

    task automatic t_status;
        // core currently running
        core_halted = 1'b1; core_fault = 1'b0;
        rd_chk(8'h08, 32'd1, 1'b0, "R5 halted bit0");
        core_halted = 1'b0; core_fault = 1'b1;
        rd_chk(8'h08, 32'd2, 1'b0, "R5 fault bit1");
        core_halted = 1'b1; core_fault = 1'b1;
        rd_chk(8'h08, 32'd3, 1'b0, "R5 both bits");
        wr(8'h00, 32'd1, 1'b0, "R6 hold");
        rd_chk(8'h08, 32'd0, 1'b0, "R6 masked while held");
        core_halted = 1'b0; core_fault = 1'b0;
        wr(8'h00, 32'd0, 1'b0, "R6 release");
        rd_chk(8'h08, 32'd0, 1'b0, "R5 idle status");
    endtask

    task automatic t_stat_write;
        wr(8'h08, 32'hFFFF_FFFF, 1'b0, "R7 status write no err");
        rd_chk(8'h00, 32'd0, 1'b0, "R7 ctl unchanged");
        rd_chk(8'h04, 32'h0000_0200, 1'b0, "R7 pc unchanged");
        eq("R7 core_rst unchanged", {31'd0, core_rst}, 32'd0);
    endtask

    task automatic t_undefined;
        rd_chk(8'h0C, 32'd0, 1'b1, "R8 undefined read");
        rd_chk(8'hFC, 32'd0, 1'b1, "R8 top of window");
        rd_chk(8'h02, 32'd0, 1'b1, "R8 unaligned");
        wr(8'h10, 32'h1234_5678, 1'b1, "R8 undefined write");
        wr(8'h01, 32'h0000_0001, 1'b1, "R8 unaligned write");
        rd_chk(8'h00, 32'd0, 1'b0, "R8 ctl unchanged");
        rd_chk(8'h04, 32'h0000_0200, 1'b0, "R8 pc unchanged");
    endtask

    initial begin
        t_reset();
        t_pc_and_release();
        t_pc_while_running();
        t_status();
        t_stat_write();
        t_undefined();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule